// File: doc/BRIEF.md
# Pixel Sampling Timing Sequencer

This block is the digital timing core of a line-sensor digitiser. A free-running master clock drives it, and a short sync pulse marks each pixel. The block works out the rising edge on which each pixel is sampled and raises a one-cycle sample strobe there. The converter answers by presenting a word of conversion data, and the block latches it. After a fixed latency that depends on the pixel ratio, the block shifts each word out serially, MSB first, on falling clock edges.

There are two pixel ratios: 12 clocks per pixel or 16 clocks per pixel. The block locks onto whichever sync pulse arrives, so a pulse that comes early or stays high too long moves the sampling point without any error handling. If the sync input stays high for a long run of clocks, the block enters a sleep state and its serial output is released. It wakes on the first clock edge that sees the sync input low.

Top module: `pixsample_seq`

## Requirements
- R1: `sample_strobe` is high for exactly the one cycle after a rising edge that sees `sync_pulse` low when the previous rising edge saw it high. It is low in every other cycle.
- R2: A sync pulse that stays high across several rising edges gives one strobe only, timed from the last high edge.
- R3: A pulse that arrives after fewer low edges than nominal restarts the timing. Its pixel is sampled on the next edge and reaches the output at its own latency. When its MSB slot comes, any bits of the earlier word not yet sent are dropped.
- R4: The word shifted out for a pixel is the value of `conv_word` at the rising edge that ends that pixel's strobe cycle.
- R5: With `long_ratio` = 0 (12:1), call the sample edge S. The MSB is driven on the falling edge that follows rising edge S+24, and the other 11 bits come in order on the next 11 falling edges.
- R6: With `long_ratio` = 1 (16:1), the MSB comes on the falling edge after rising edge S+32. Every falling edge that carries no word bit drives 0, so pixels spaced 16 clocks apart have four zero bits between words.
- R7: Right after reset, `sample_strobe`=0, `sleep`=0, `ser_oe`=1 and `ser_data`=0. `ser_data` stays 0 until the first word reaches its MSB slot.
- R8: `sleep` rises, and `ser_oe` falls, after the 64th consecutive rising edge that sees `sync_pulse` high. A run of 63 high edges does not cause sleep.
- R9: The first rising edge that sees `sync_pulse` low clears `sleep` and sets `ser_oe`. That edge also counts as a sample edge under R1.
- R10: While asleep, `ser_data` is 0 and no strobe is raised. Words still waiting are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; sampling on rising edges, serial data on falling edges |
| rst | input | 1 | Synchronous active-high reset |
| sync_pulse | input | 1 | Pixel sync pulse, nominally high for one rising edge per pixel |
| long_ratio | input | 1 | 0 = 12 clocks per pixel, 1 = 16 clocks per pixel |
| conv_word | input | 12 | Conversion result, latched at the edge that ends the strobe cycle |
| sample_strobe | output | 1 | One-cycle pulse marking the sample edge |
| ser_data | output | 1 | Serial data, MSB first, updated on falling edges |
| ser_oe | output | 1 | Output enable for `ser_data`; low while asleep |
| sleep | output | 1 | Sleep flag |

## Verification
The bench builds the block with its default parameters: a 12-bit word, periods of 12 and 16 clocks, a pipeline two pixel periods deep (latencies of 24 and 32 cycles), three pending slots and a 64-edge sleep threshold. With this small threshold, both the 63-edge near miss and a full sleep and wake take only a few hundred cycles. The two latencies together with the three-slot store let random pulse spacings, early pulses and stretched pulses all be checked against a bench model of the bit expected on every falling edge.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic {
    RATIO_SHORT = 1'b0,
    RATIO_LONG  = 1'b1
  } ratio_e;
endpackage

// File: rtl/pss_pulse_watch.sv
// Watches the sync input on rising edges: finds sample edges and the sleep run.
module pss_pulse_watch #(
  parameter int SLEEP_EDGES = 64  // must be at least 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  output logic fall_now,
  output logic strobe,
  output logic asleep
);
  localparam int HC_W = $clog2(SLEEP_EDGES);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(SLEEP_EDGES - 1);

  logic            prev_q;
  logic [HC_W-1:0] hi_cnt;

  // Sample edge: first rising edge low after a high one.
  assign fall_now = prev_q & ~pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      strobe <= 1'b0;
      hi_cnt <= '0;
      asleep <= 1'b0;
    end else begin
      prev_q <= pulse;
      strobe <= fall_now;
      if (pulse) begin
        if (!asleep) begin
          if (hi_cnt == HC_LAST) asleep <= 1'b1;
          else                   hi_cnt <= hi_cnt + HC_W'(1);
        end
      end else begin
        hi_cnt <= '0;
        asleep <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pss_pending.sv
// Words in flight: each slot counts down its latency on rising edges.
module pss_pending
  import pss_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int SLOTS     = 3,
  parameter int LAT_SHORT = 24,
  parameter int LAT_LONG  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc,
  input  ratio_e            ratio,
  input  logic              cap,
  input  logic [WORD_W-1:0] cap_word,
  output logic              launch,
  output logic [WORD_W-1:0] launch_word
);
  localparam int LAT_MAX = (LAT_LONG > LAT_SHORT) ? LAT_LONG : LAT_SHORT;
  localparam int CNT_W   = $clog2(LAT_MAX);
  localparam int IDX_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(LAT_SHORT - 1);
  localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(LAT_LONG - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(SLOTS - 1);

  logic [SLOTS-1:0]  busy;
  logic [CNT_W-1:0]  cnt  [SLOTS];
  logic [WORD_W-1:0] word [SLOTS];
  logic [IDX_W-1:0]  wr_ptr;
  logic [IDX_W-1:0]  cap_idx;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;

  // Lowest-index expiring slot wins if two expire together.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (busy[i] && cnt[i] == '0) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // Word storage: plain write port, read on launch, no reset.
  always_ff @(posedge clk) begin
    if (cap) word[cap_idx] <= cap_word;
    if (hit) launch_word <= word[hit_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy    <= '0;
      wr_ptr  <= '0;
      cap_idx <= '0;
      launch  <= 1'b0;
    end else begin
      launch <= hit;
      for (int i = 0; i < SLOTS; i++) begin
        if (busy[i]) begin
          if (cnt[i] == '0) busy[i] <= 1'b0;
          else              cnt[i]  <= cnt[i] - CNT_W'(1);
        end
      end
      if (alloc) begin
        busy[wr_ptr] <= 1'b1;
        cnt[wr_ptr]  <= (ratio == RATIO_LONG) ? LOAD_LONG : LOAD_SHORT;
        cap_idx      <= wr_ptr;
        wr_ptr       <= (wr_ptr == IDX_LAST) ? '0 : wr_ptr + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/pss_shift_out.sv
// Falling-edge serializer: loads on launch, shifts zeros in behind the word.
module pss_shift_out #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  output logic              bit_out
);
  logic [WORD_W-1:0] sr;

  always_ff @(negedge clk) begin
    if (rst || clear) sr <= '0;
    else if (load)    sr <= load_word;
    else              sr <= {sr[WORD_W-2:0], 1'b0};
  end

  assign bit_out = sr[WORD_W-1];
endmodule

// File: rtl/pixsample_seq.sv
module pixsample_seq #(
  parameter int WORD_W       = 12,
  parameter int SHORT_PERIOD = 12,
  parameter int LONG_PERIOD  = 16,
  parameter int PIPE_PERIODS = 2,
  parameter int SLEEP_EDGES  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_pulse,
  input  logic              long_ratio,
  input  logic [WORD_W-1:0] conv_word,
  output logic              sample_strobe,
  output logic              ser_data,
  output logic              ser_oe,
  output logic              sleep
);
  localparam int LAT_SHORT = SHORT_PERIOD * PIPE_PERIODS;
  localparam int LAT_LONG  = LONG_PERIOD * PIPE_PERIODS;
  localparam int SLOTS     = PIPE_PERIODS + 1;

  logic              fall_now;
  logic              asleep;
  logic              launch;
  logic [WORD_W-1:0] launch_word;

  pss_pulse_watch #(.SLEEP_EDGES(SLEEP_EDGES)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .pulse   (sync_pulse),
    .fall_now(fall_now),
    .strobe  (sample_strobe),
    .asleep  (asleep)
  );

  pss_pending #(
    .WORD_W   (WORD_W),
    .SLOTS    (SLOTS),
    .LAT_SHORT(LAT_SHORT),
    .LAT_LONG (LAT_LONG)
  ) u_pending (
    .clk        (clk),
    .rst        (rst),
    .flush      (asleep & sync_pulse),
    .alloc      (fall_now),
    .ratio      (pss_pkg::ratio_e'(long_ratio)),
    .cap        (sample_strobe),
    .cap_word   (conv_word),
    .launch     (launch),
    .launch_word(launch_word)
  );

  pss_shift_out #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clear    (asleep),
    .load     (launch),
    .load_word(launch_word),
    .bit_out  (ser_data)
  );

  assign ser_oe = ~asleep;
  assign sleep  = asleep;
endmodule

// File: rtl/pixsample_seq_chk.sv
module pixsample_seq_chk (
  input logic clk,
  input logic rst,
  input logic sync_pulse,
  input logic sample_strobe,
  input logic ser_data,
  input logic ser_oe,
  input logic sleep
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1
  strobe_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(sync_pulse) && !sync_pulse) |=> sample_strobe);

  // R1
  no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !($past(sync_pulse) && !sync_pulse)) |=> !sample_strobe);

  // R8
  sleep_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(sleep)) |-> $past(sync_pulse));

  // R9
  wake_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep && !sync_pulse) |=> (!sleep && ser_oe));

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (!ser_data && !sample_strobe));
endmodule

bind pixsample_seq pixsample_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .sync_pulse   (sync_pulse),
  .sample_strobe(sample_strobe),
  .ser_data     (ser_data),
  .ser_oe       (ser_oe),
  .sleep        (sleep)
);

// File: tb/pixsample_seq_test.sv
module pixsample_seq_test;
  localparam int DEPTH = 16384;

  logic        clk = 1'b0;
  logic        rst;
  logic        sync_pulse;
  logic        long_ratio;
  logic [11:0] conv_word;
  logic        sample_strobe, ser_data, ser_oe, sleep;

  pixsample_seq uut (
    .clk(clk), .rst(rst), .sync_pulse(sync_pulse), .long_ratio(long_ratio),
    .conv_word(conv_word), .sample_strobe(sample_strobe), .ser_data(ser_data),
    .ser_oe(ser_oe), .sleep(sleep)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    m_hi = 0;
  bit    m_prev = 1'b0;
  bit    m_sleep = 1'b0;
  bit    done = 1'b0;
  string strobe_tag = "R1";
  string data_tag = "R7";
  logic [12:0] lw [DEPTH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Bit expected after the falling edge of cycle c: latest launch wins, zeros otherwise.
  function automatic logic exp_bit(input int c);
    for (int k = 0; k < 12; k++)
      if (c - k >= 0 && lw[c - k][12]) return lw[c - k][11 - k];
    return 1'b0;
  endfunction

  task automatic step(input bit p);
    bit          fall;
    logic [11:0] w;
    int          lat;
    sync_pulse = p;
    @(posedge clk);
    cyc++;
    fall = m_prev && !p;
    if (p) begin
      if (!m_sleep) begin
        if (m_hi == 63) m_sleep = 1'b1;
        else            m_hi++;
      end
    end else begin
      m_hi    = 0;
      m_sleep = 1'b0;
    end
    m_prev = p;
    #1;
    chk(sample_strobe == fall, strobe_tag, sample_strobe, fall);
    if (fall) begin
      w         = 12'($urandom);
      conv_word = w;
      lat       = long_ratio ? 32 : 24;
      if (cyc + lat < DEPTH) lw[cyc + lat] = {1'b1, w};
    end
    chk(sleep == m_sleep && ser_oe == !m_sleep, "R8", {sleep, ser_oe}, {m_sleep, !m_sleep});
    #4;
    if (m_sleep) chk(ser_data == 1'b0, "R10", ser_data, 0);
    else         chk(ser_data == exp_bit(cyc), data_tag, ser_data, exp_bit(cyc));
  endtask

  task automatic pixel(input int h, input int l);
    strobe_tag = (h > 1) ? "R2" : "R1";
    repeat (h) step(1'b1);
    repeat (l) step(1'b0);
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < DEPTH; i++) lw[i] = '0;
    rst = 1'b1; sync_pulse = 1'b0; long_ratio = 1'b0; conv_word = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    #4;
    // R7 reset state
    chk(sample_strobe == 1'b0, "R7", sample_strobe, 0);
    chk(sleep == 1'b0, "R7", sleep, 0);
    chk(ser_oe == 1'b1, "R7", ser_oe, 1);
    chk(ser_data == 1'b0, "R7", ser_data, 0);
    repeat (20) step(1'b0);

    // 12:1 nominal, then random spacing with stretched and early pulses (R4, R5)
    data_tag = "R5 R4";
    repeat (10) pixel(1, 11);
    for (int n = 0; n < 150; n++) pixel($urandom_range(3, 1), $urandom_range(13, 7));

    // R3 early pulse cutting an unfinished word
    data_tag = "R3";
    repeat (3) pixel(1, 11);
    pixel(1, 6);
    repeat (4) pixel(1, 11);
    strobe_tag = "R3";
    pixel(1, 4);
    repeat (4) pixel(1, 11);

    // R8 near miss: 63 high edges
    data_tag = "R5";
    repeat (63) step(1'b1);
    chk(sleep == 1'b0, "R8", sleep, 0);
    strobe_tag = "R9";
    step(1'b0);
    repeat (3) pixel(1, 11);
    repeat (40) step(1'b0);

    // R8 full run then R10 while asleep, then wake in 16:1 (R9)
    repeat (64) step(1'b1);
    chk(sleep == 1'b1 && ser_oe == 1'b0, "R8", {sleep, ser_oe}, 2);
    repeat (10) step(1'b1);
    chk(ser_data == 1'b0 && sample_strobe == 1'b0, "R10", {ser_data, sample_strobe}, 0);
    long_ratio = 1'b1;
    strobe_tag = "R9";
    step(1'b0);
    chk(sleep == 1'b0 && ser_oe == 1'b1 && sample_strobe == 1'b1, "R9",
        {sleep, ser_oe, sample_strobe}, 3);
    data_tag = "R6";
    repeat (14) step(1'b0);
    repeat (10) pixel(1, 15);
    for (int n = 0; n < 120; n++) pixel($urandom_range(2, 1), $urandom_range(17, 11));
    repeat (50) step(1'b0);

    // back to 12:1 through another sleep
    repeat (70) step(1'b1);
    long_ratio = 1'b0;
    data_tag = "R5";
    step(1'b0);
    repeat (20) pixel(1, 11);
    repeat (40) step(1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog cycle %0d actual=hung expected=finished", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule